// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display pipeline. One clock cycle is one character of 8 pixels. The block runs a character counter across each line and a line counter across each frame. From those counters it derives display-enable, horizontal sync and vertical sync, and it pulses a strobe whenever a new frame begins.

The timing comes from a bank of byte-wide registers. Software reaches the bank through a two-step port. A write with the select bit low loads the index. A write with the select bit high stores the byte into the register that index names. Each field is stored with its own bias. Wide fields are split into a low byte and high bits held at another index. The two sync-end fields keep only their low bits, and a sync pulse ends at the first later counter value whose low bits match. A lock bit blocks writes to the horizontal registers.

Sync polarity arrives on a separate two-bit write port. Every programmed value is held in a staging copy and only takes effect at the next frame boundary, so a running frame never sees a mix of old and new settings. Out of reset the block runs a 640x480 mode with negative syncs.

Top module: `crt_raster_gen`

## Requirements
- R1: After reset both counters are 0. The mode is 100 characters per line: display on characters 0..79 and hsync on characters 82..93. It has 525 lines per frame: display on lines 0..479 and vsync on lines 490..491. Both syncs are active low. The lock bit is clear.
- R2: A write with `reg_sel`=0 loads the 8-bit index. A write with `reg_sel`=1 stores `reg_wdata` into the register that index names. Indices other than 0-4 and 8-14 have no effect.
- R3: `char_cnt` counts 0 up to T+4 and then wraps to 0. T is the 9-bit horizontal total field: bits 7:0 at index 0 and bit 8 at bit 0 of index 4. A line is therefore T+5 characters long.
- R4: `disp_en` is high exactly when `char_cnt` <= the display-end byte at index 1 and `line_cnt` <= the 12-bit vertical display-end field. That field takes bits 7:0 from index 10 and bits 11:8 from bits 3:0 of index 11.
- R5: The horizontal sync becomes active when `char_cnt` equals the start byte at index 2. It stays active until the first later character whose bits 4:0 equal bits 4:0 of index 3.
- R6: `line_cnt` advances when `char_cnt` wraps. It wraps to 0 after line V+1, where V is the 12-bit vertical total field: bits 7:0 at index 8 and bits 11:8 from bits 3:0 of index 9.
- R7: The vertical sync becomes active on line S+1. S is the 12-bit start field: bits 7:0 at index 12 and bits 11:8 from bits 3:0 of index 13. The sync stays active until the first later line L for which bits 3:0 of L-1 equal bits 3:0 of index 14.
- R8: Bit 7 of index 14 is a lock. While it is 1, data writes to indices 0 through 7 are ignored. Index 14 itself can always be written.
- R9: A write on `misc_wr` sets the polarity. Bit 0 of `misc_wdata` set makes `hsync` active low, and bit 1 set makes `vsync` active low.
- R10: Register and polarity changes take effect on the frame that starts after the write. `sof` is high for exactly the one cycle in which both counters have just wrapped to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 = write index, 1 = write data |
| reg_wdata | input | 8 | Index or data byte |
| misc_wr | input | 1 | Polarity write strobe |
| misc_wdata | input | 2 | Bit 0 hsync active-low, bit 1 vsync active-low |
| char_cnt | output | HW | Character counter |
| line_cnt | output | VW | Line counter |
| disp_en | output | 1 | Active display area |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| sof | output | 1 | One-cycle start-of-frame strobe |

## Verification
The bench compares every output on every cycle with a model built from the requirements.

It runs four timings:
- The full reset mode confirms the default biases and the negative polarity.
- A short 20x10 mode with positive syncs shows that the staged values switch in only at a frame boundary.
- A 60x30 mode places the sync-end fields numerically below the sync-start fields, so a full-width end compare would never match. This case separates a correct low-bit match from a full-width one.
- Measured frame lengths with the lock set and then cleared show that a locked write leaves the line length unchanged and an unlocked one takes effect.

// File: rtl/crt_raster_gen.sv
module crt_raster_gen #(
  parameter int HW        = 10,
  parameter int VW        = 13,
  parameter int DEF_HDISP = 80,
  parameter int DEF_HFP   = 2,
  parameter int DEF_HSYNC = 12,
  parameter int DEF_HBP   = 6,
  parameter int DEF_VDISP = 480,
  parameter int DEF_VFP   = 10,
  parameter int DEF_VSYNC = 2,
  parameter int DEF_VBP   = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          misc_wr,
  input  logic [1:0]    misc_wdata,
  output logic [HW-1:0] char_cnt,
  output logic [VW-1:0] line_cnt,
  output logic          disp_en,
  output logic          hsync,
  output logic          vsync,
  output logic          sof
);
  localparam int HTOT = DEF_HDISP + DEF_HFP + DEF_HSYNC + DEF_HBP;
  localparam int VTOT = DEF_VDISP + DEF_VFP + DEF_VSYNC + DEF_VBP;
  localparam logic [8:0]  R_HTOT = 9'(HTOT - 5);
  localparam logic [7:0]  R_HDE  = 8'(DEF_HDISP - 1);
  localparam logic [7:0]  R_HSS  = 8'(DEF_HDISP + DEF_HFP);
  localparam logic [4:0]  R_HSE  = 5'(DEF_HDISP + DEF_HFP + DEF_HSYNC);
  localparam logic [11:0] R_VTOT = 12'(VTOT - 2);
  localparam logic [11:0] R_VDE  = 12'(DEF_VDISP - 1);
  localparam logic [11:0] R_VSS  = 12'(DEF_VDISP + DEF_VFP - 1);
  localparam logic [3:0]  R_VSE  = 4'(DEF_VDISP + DEF_VFP + DEF_VSYNC - 1);

  logic [7:0]  idx;
  logic [8:0]  p_htot, a_htot;
  logic [7:0]  p_hde, a_hde, p_hss, a_hss;
  logic [4:0]  p_hse, a_hse;
  logic [11:0] p_vtot, a_vtot, p_vde, a_vde, p_vss, a_vss;
  logic [3:0]  p_vse, a_vse;
  logic [1:0]  p_pol, a_pol;
  logic        p_lock;
  logic        hs_on, vs_on;

  wire data_wr = reg_wr && reg_sel;
  wire h_ok    = !p_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      p_htot <= R_HTOT; p_hde <= R_HDE; p_hss <= R_HSS; p_hse <= R_HSE;
      p_vtot <= R_VTOT; p_vde <= R_VDE; p_vss <= R_VSS; p_vse <= R_VSE;
      p_lock <= 1'b0;   p_pol <= 2'b11;
    end else begin
      if (reg_wr && !reg_sel) idx <= reg_wdata;
      if (misc_wr) p_pol <= misc_wdata;
      if (data_wr) begin
        case (idx)
          8'd0:  if (h_ok) p_htot[7:0] <= reg_wdata;
          8'd1:  if (h_ok) p_hde <= reg_wdata;
          8'd2:  if (h_ok) p_hss <= reg_wdata;
          8'd3:  if (h_ok) p_hse <= reg_wdata[4:0];
          8'd4:  if (h_ok) p_htot[8] <= reg_wdata[0];
          8'd8:  p_vtot[7:0]  <= reg_wdata;
          8'd9:  p_vtot[11:8] <= reg_wdata[3:0];
          8'd10: p_vde[7:0]   <= reg_wdata;
          8'd11: p_vde[11:8]  <= reg_wdata[3:0];
          8'd12: p_vss[7:0]   <= reg_wdata;
          8'd13: p_vss[11:8]  <= reg_wdata[3:0];
          8'd14: begin p_lock <= reg_wdata[7]; p_vse <= reg_wdata[3:0]; end
          default: ;
        endcase
      end
    end
  end

  wire h_last    = (char_cnt == HW'(a_htot) + HW'(4));
  wire v_last    = (line_cnt == VW'(a_vtot) + VW'(1));
  wire frame_end = h_last && v_last;

  wire [HW-1:0] h_nxt = h_last ? '0 : char_cnt + HW'(1);
  wire [VW-1:0] v_nxt = !h_last ? line_cnt : (v_last ? '0 : line_cnt + VW'(1));
  wire [VW-1:0] vm1_nxt = v_nxt - VW'(1);

  wire [7:0]  n_hss = frame_end ? p_hss : a_hss;
  wire [4:0]  n_hse = frame_end ? p_hse : a_hse;
  wire [11:0] n_vss = frame_end ? p_vss : a_vss;
  wire [3:0]  n_vse = frame_end ? p_vse : a_vse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_cnt <= '0; line_cnt <= '0; sof <= 1'b0;
      hs_on <= 1'b0;  vs_on <= 1'b0;
      a_htot <= R_HTOT; a_hde <= R_HDE; a_hss <= R_HSS; a_hse <= R_HSE;
      a_vtot <= R_VTOT; a_vde <= R_VDE; a_vss <= R_VSS; a_vse <= R_VSE;
      a_pol <= 2'b11;
    end else begin
      char_cnt <= h_nxt;
      line_cnt <= v_nxt;
      sof      <= frame_end;
      if (h_nxt == HW'(n_hss))                     hs_on <= 1'b1;
      else if (hs_on && h_nxt[4:0] == n_hse)       hs_on <= 1'b0;
      if (vm1_nxt == VW'(n_vss))                   vs_on <= 1'b1;
      else if (vs_on && vm1_nxt[3:0] == n_vse)     vs_on <= 1'b0;
      if (frame_end) begin
        a_htot <= p_htot; a_hde <= p_hde; a_hss <= p_hss; a_hse <= p_hse;
        a_vtot <= p_vtot; a_vde <= p_vde; a_vss <= p_vss; a_vse <= p_vse;
        a_pol  <= p_pol;
      end
    end
  end

  assign disp_en = (char_cnt <= HW'(a_hde)) && (line_cnt <= VW'(a_vde));
  assign hsync   = hs_on ^ a_pol[0];
  assign vsync   = vs_on ^ a_pol[1];

  AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (char_cnt == '0 && line_cnt == '0)); // R10
  AST_CHAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    char_cnt <= HW'(a_htot) + HW'(4)); // R3
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_cnt) |-> char_cnt == '0); // R6
  AST_HSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    (char_cnt == HW'(a_hss) && !sof) |-> hs_on); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && p_lock && idx < 8'd8) |=> ($stable(p_htot) && $stable(p_hde) && $stable(p_hss) && $stable(p_hse))); // R8
  AST_STAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> ($stable(a_htot) && $stable(a_vtot) && $stable(a_pol))); // R10
endmodule

// File: tb/test_crt_raster_gen.sv
module test_crt_raster_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, misc_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] misc_wdata = '0;
  logic [9:0] char_cnt;
  logic [12:0] line_cnt;
  logic disp_en, hsync, vsync, sof;

  crt_raster_gen i_crt_raster_gen (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  // model: active and staged settings
  int a_ht = 100, a_hde = 79, a_hss = 82, a_hse = 30, a_vt = 525, a_vde = 479, a_vss = 489, a_vse = 11, a_pol = 3;
  int p_ht = 100, p_hde = 79, p_hss = 82, p_hse = 30, p_vt = 525, p_vde = 479, p_vss = 489, p_vse = 11, p_pol = 3;
  int p_lock = 0, m_idx = 0, m_h = 0, m_v = 0, m_sof = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int h_active(int h);
    int e = a_hss + 1;
    while (e % 32 != a_hse) e++;
    return (h >= a_hss && h < e) ? 1 : 0;
  endfunction

  function automatic int v_active(int v);
    int s = a_vss + 1;
    int e = s + 1;
    while ((e - 1) % 16 != a_vse) e++;
    return (v >= s && v < e) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int hx = h_active(m_h) ^ (a_pol & 1);
    int vx = v_active(m_v) ^ ((a_pol >> 1) & 1);
    chk("R3 char_cnt", int'(char_cnt), m_h);
    chk("R6 line_cnt", int'(line_cnt), m_v);
    chk("R4 disp_en", int'(disp_en), (m_h <= a_hde && m_v <= a_vde) ? 1 : 0);
    chk("R5/R9 hsync", int'(hsync), hx);
    chk("R7/R9 vsync", int'(vsync), vx);
    chk("R10 sof", int'(sof), m_sof);
  endtask

  task automatic apply_write(input int sel, input int d);
    if (sel == 0) begin m_idx = d; return; end
    if (m_idx < 8 && p_lock != 0) return;
    case (m_idx)
      0: p_ht = ((p_ht - 5) & 'h100 | d) + 5;
      1: p_hde = d;
      2: p_hss = d;
      3: p_hse = d & 31;
      4: p_ht = (((p_ht - 5) & 'hff) | ((d & 1) << 8)) + 5;
      8: p_vt = (((p_vt - 2) & 'hf00) | d) + 2;
      9: p_vt = (((p_vt - 2) & 'hff) | ((d & 15) << 8)) + 2;
      10: p_vde = (p_vde & 'hf00) | d;
      11: p_vde = (p_vde & 'hff) | ((d & 15) << 8);
      12: p_vss = (p_vss & 'hf00) | d;
      13: p_vss = (p_vss & 'hff) | ((d & 15) << 8);
      14: begin p_lock = (d >> 7) & 1; p_vse = d & 15; end
      default: ;
    endcase
  endtask

  task automatic tick(input int wr = 0, input int sel = 0, input int d = 0, input int mwr = 0, input int mp = 0);
    reg_wr = wr[0]; reg_sel = sel[0]; reg_wdata = d[7:0];
    misc_wr = mwr[0]; misc_wdata = mp[1:0];
    @(posedge clk); #1;
    m_sof = 0;
    if (m_h == a_ht - 1) begin
      m_h = 0;
      if (m_v == a_vt - 1) begin
        m_v = 0; m_sof = 1;
        a_ht = p_ht; a_hde = p_hde; a_hss = p_hss; a_hse = p_hse;
        a_vt = p_vt; a_vde = p_vde; a_vss = p_vss; a_vse = p_vse; a_pol = p_pol;
      end else m_v++;
    end else m_h++;
    if (wr != 0) apply_write(sel, d);
    if (mwr != 0) p_pol = mp;
    reg_wr = 1'b0; misc_wr = 1'b0;
    compare_all();
  endtask

  task automatic wreg(input int index, input int val);
    tick(1, 0, index);
    tick(1, 1, val);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measure_frame(output int len);
    while (sof !== 1'b1) tick();
    len = 0;
    do begin tick(); len++; end while (sof !== 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 reset char_cnt", int'(char_cnt), 0);
    chk("R1 reset line_cnt", int'(line_cnt), 0);
    chk("R1 reset disp_en", int'(disp_en), 1);
    chk("R1 reset hsync idle high", int'(hsync), 1);
    chk("R1 reset vsync idle high", int'(vsync), 1);
    chk("R1 reset sof", int'(sof), 0);
  endtask

  task automatic t_default_frame();
    run(100 * 525);
    chk("R1 default frame length 52500", int'(sof), 1);
  endtask

  task automatic t_small_mode();
    int len;
    wreg(0, 15); wreg(4, 0); wreg(1, 11); wreg(2, 14); wreg(3, 17);
    wreg(8, 8); wreg(9, 0); wreg(10, 5); wreg(11, 0); wreg(12, 6); wreg(13, 0);
    wreg(14, 8);
    tick(0, 0, 0, 1, 0);
    chk("R10 staged values not yet active", int'(char_cnt) < 100 ? 1 : 0, 1);
    measure_frame(len);
    measure_frame(len);
    chk("R2 small frame length", len, 200);
  endtask

  task automatic t_lowbit_end();
    int len;
    wreg(0, 55); wreg(1, 31); wreg(2, 40); wreg(3, 13);
    wreg(8, 28); wreg(10, 20); wreg(12, 19); wreg(14, 5);
    measure_frame(len);
    measure_frame(len);
    chk("R5 R7 low-bit end frame length", len, 1800);
  endtask

  task automatic t_lock();
    int len;
    wreg(14, 'h85);
    wreg(0, 15);
    wreg(3, 2);
    measure_frame(len);
    measure_frame(len);
    chk("R8 locked write ignored", len, 1800);
    wreg(14, 5);
    wreg(0, 15);
    measure_frame(len);
    measure_frame(len);
    chk("R8 unlocked write applied", len, 600);
    wreg(20, 99);
    measure_frame(len);
    chk("R2 unused index no effect", len, 600);
    tick(0, 0, 0, 1, 3);
    measure_frame(len);
    run(30);
    chk("R9 polarity restored low-active", int'(hsync), 1);
  endtask

  bit done = 0;
  initial begin
    #(8 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_default_frame();
    t_small_mode();
    t_lowbit_end();
    t_lock();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule